// File: doc/BRIEF.md
# Tagged Output Queue with Threshold Service Request

This block queues bytes that an internal processor sends to an external host. Every entry carries one tag bit on top of its eight data bits. The tag says whether the entry is plain data or an in-band stream command. The producer side is a simple push interface. A push attempted while the queue is full is dropped, and the producer is told so by a one-cycle reject pulse.

The consumer reads plain data with either a host read strobe or a DMA acknowledge. When the entry at the head is a command, it is not handed out as data. It is shown instead on a separate command port, which has its own read strobe. Commands therefore stay in order with the surrounding bytes.

The host programs a threshold. A service request is raised when the queue holds at least that many entries. It is also raised whenever a command that closes a block is still waiting to be read. The request is steered to a DMA request output or to an interrupt output, depending on whether DMA is enabled. A data read from an empty queue sets an underrun flag, which holds until the host reads status.

Top module: `ofq_tagged_out`

## Requirements
- R1: After reset the queue is empty (`count` = 0), and `svc_req`, `underrun`, `flush_active`, `push_reject`, `data_valid` and `cmd_present` are all 0. The threshold resets to 0.
- R2: Data entries (tag 0) leave in push order. `rd_byte` shows the head byte while `data_valid` is 1, and a `host_rd` or `dma_ack` pulse removes it.
- R3: A push while `count` equals DEPTH is dropped, so the contents and `count` are unchanged. `push_reject` is then 1 for exactly the following cycle.
- R4: `svc_req` is 1 whenever `count` is greater than or equal to the programmed threshold. A programmed threshold of 0 acts as 1.
- R5: While any pushed command entry (`push_cmd` = 1) has not yet been read through the command port, `flush_active` is 1 and `svc_req` is 1, whatever the threshold. `flush_active` returns to 0 once the last such command is read.
- R6: When the head entry has tag 1, `cmd_present` is 1, `cmd_byte` shows its byte and `data_valid` is 0. In that state a data read removes nothing and does not set the underrun flag.
- R7: A `cmd_rd` while the queue is empty or the head is data has no effect on the queue.
- R8: A data read (`host_rd` or `dma_ack`) while `count` is 0 sets `underrun`. The flag stays set until a `status_rd`. If a new underrun and `status_rd` fall in the same cycle, the flag stays set.
- R9: `drq_out` equals `svc_req` when `dma_en` is 1 and is 0 otherwise. `intrq_out` equals `svc_req` when `dma_en` is 0 and is 0 otherwise.
- R10: `count` always equals the number of stored entries, data and commands together, and never exceeds DEPTH.

Ports (below): CW = $clog2(DEPTH+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Producer push strobe |
| push_byte | input | 8 | Byte to push |
| push_cmd | input | 1 | Tag of pushed entry, 1 marks a stream command |
| push_reject | output | 1 | One-cycle pulse after a push into a full queue |
| thr_wr | input | 1 | Load strobe for the threshold |
| thr_val | input | CW | Threshold value |
| dma_en | input | 1 | Steers the service request to DMA (1) or interrupt (0) |
| host_rd | input | 1 | Host data read strobe |
| dma_ack | input | 1 | DMA acknowledge, reads data like `host_rd` |
| cmd_rd | input | 1 | Read strobe of the command port |
| status_rd | input | 1 | Host status read, clears the underrun flag |
| rd_byte | output | 8 | Head byte when the head is data |
| data_valid | output | 1 | Head entry is data |
| cmd_byte | output | 8 | Head byte when the head is a command |
| cmd_present | output | 1 | Head entry is a command |
| count | output | CW | Number of stored entries |
| underrun | output | 1 | Sticky empty-read flag |
| flush_active | output | 1 | Unread command pending |
| svc_req | output | 1 | Service request |
| drq_out | output | 1 | Service request as DMA request |
| intrq_out | output | 1 | Service request as interrupt |

## Verification
Every stored quantity changes only at a clock edge. The head views, `count`, `svc_req`, the two routed requests, `underrun` and `flush_active` therefore show a stimulus one edge after it is applied. `push_reject` follows its rejected push by one edge and lasts one cycle. The bench drives inputs on the falling edge and updates its reference model with the same inputs at the rising edge. It compares every output at the next falling edge, so each check lands exactly one edge after its cause.

// File: rtl/ofq_pkg.sv
package ofq_pkg;
    localparam int OFQ_BW = 8;

    typedef struct packed {
        logic              tag;
        logic [OFQ_BW-1:0] val;
    } ofq_entry_t;
endpackage

// File: rtl/ofq_ring.sv
module ofq_ring
    import ofq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  ofq_entry_t wr_ent,
    input  logic       rd_en,
    output ofq_entry_t head,
    output logic [CW-1:0] level
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] lvl;
    } ring_t;

    ring_t      st_d, st_q;
    ofq_entry_t mem [DEPTH];

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.wp = adv(st_q.wp);
        if (rd_en) st_d.rp = adv(st_q.rp);
        st_d.lvl = st_q.lvl + CW'(wr_en) - CW'(rd_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[st_q.wp] <= wr_ent;
    end

    assign head  = mem[st_q.rp];
    assign level = st_q.lvl;
endmodule

// File: rtl/ofq_flags.sv
module ofq_flags #(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] level,
    input  logic          push_ok,
    input  logic          push_tag,
    input  logic          push_blocked,
    input  logic          cmd_pop,
    input  logic          empty_read,
    input  logic          status_rd,
    input  logic          thr_wr,
    input  logic [CW-1:0] thr_val,
    output logic          svc_req,
    output logic          flush_active,
    output logic          underrun,
    output logic          push_reject
);
    typedef struct packed {
        logic [CW-1:0] thr;
        logic [CW-1:0] pend;
        logic          ur;
        logic          rej;
    } flag_t;

    flag_t         fl_d, fl_q;
    logic [CW-1:0] eff_thr;

    always_comb begin
        fl_d      = fl_q;
        if (thr_wr) fl_d.thr = thr_val;
        fl_d.pend = fl_q.pend + CW'(push_ok & push_tag) - CW'(cmd_pop);
        fl_d.ur   = empty_read | (fl_q.ur & ~status_rd);
        fl_d.rej  = push_blocked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign eff_thr      = (fl_q.thr == '0) ? CW'(1) : fl_q.thr;
    assign flush_active = (fl_q.pend != '0);
    assign svc_req      = (level >= eff_thr) | flush_active;
    assign underrun     = fl_q.ur;
    assign push_reject  = fl_q.rej;
endmodule

// File: rtl/ofq_tagged_out.sv
module ofq_tagged_out
    import ofq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [7:0]    push_byte,
    input  logic          push_cmd,
    output logic          push_reject,
    input  logic          thr_wr,
    input  logic [CW-1:0] thr_val,
    input  logic          dma_en,
    input  logic          host_rd,
    input  logic          dma_ack,
    input  logic          cmd_rd,
    input  logic          status_rd,
    output logic [7:0]    rd_byte,
    output logic          data_valid,
    output logic [7:0]    cmd_byte,
    output logic          cmd_present,
    output logic [CW-1:0] count,
    output logic          underrun,
    output logic          flush_active,
    output logic          svc_req,
    output logic          drq_out,
    output logic          intrq_out
);
    ofq_entry_t    head, wr_ent;
    logic [CW-1:0] level;
    logic          full, empty, push_ok, data_req, data_pop, cmd_pop;

    assign full     = (level == CW'(DEPTH));
    assign empty    = (level == '0);
    assign push_ok  = push_valid & ~full;
    assign data_req = host_rd | dma_ack;
    assign data_pop = data_req & ~empty & ~head.tag;
    assign cmd_pop  = cmd_rd & ~empty & head.tag;
    assign wr_ent   = '{tag: push_cmd, val: push_byte};

    ofq_ring #(.DEPTH(DEPTH)) i_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (push_ok),
        .wr_ent (wr_ent),
        .rd_en  (data_pop | cmd_pop),
        .head   (head),
        .level  (level)
    );

    ofq_flags #(.DEPTH(DEPTH)) i_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .level        (level),
        .push_ok      (push_ok),
        .push_tag     (push_cmd),
        .push_blocked (push_valid & full),
        .cmd_pop      (cmd_pop),
        .empty_read   (data_req & empty),
        .status_rd    (status_rd),
        .thr_wr       (thr_wr),
        .thr_val      (thr_val),
        .svc_req      (svc_req),
        .flush_active (flush_active),
        .underrun     (underrun),
        .push_reject  (push_reject)
    );

    assign data_valid  = ~empty & ~head.tag;
    assign cmd_present = ~empty & head.tag;
    assign rd_byte     = data_valid  ? head.val : '0;
    assign cmd_byte    = cmd_present ? head.val : '0;
    assign count       = level;
    assign drq_out     = svc_req & dma_en;
    assign intrq_out   = svc_req & ~dma_en;
endmodule

// File: rtl/ofq_tagged_out_chk.sv
module ofq_tagged_out_chk #(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_valid,
    input logic          push_reject,
    input logic          dma_en,
    input logic          host_rd,
    input logic          dma_ack,
    input logic          cmd_rd,
    input logic          status_rd,
    input logic          data_valid,
    input logic          cmd_present,
    input logic [CW-1:0] count,
    input logic          underrun,
    input logic          flush_active,
    input logic          svc_req,
    input logic          drq_out,
    input logic          intrq_out
);
    assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_reject_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && count == CW'(DEPTH)) |=> push_reject);

    assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && count == CW'(DEPTH) && !host_rd && !dma_ack && !cmd_rd)
        |=> count == CW'(DEPTH));

    assert_underrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_rd || dma_ack) && count == '0) |=> underrun);

    assert_underrun_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !status_rd) |=> underrun);

    assert_flush_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_active |-> svc_req);

    assert_head_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_valid, cmd_present}));

    assert_cmd_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_present && !cmd_rd) |=> cmd_present);

    assert_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> (dma_en ? (drq_out && !intrq_out) : (intrq_out && !drq_out)));

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !svc_req |-> (!drq_out && !intrq_out));
endmodule

bind ofq_tagged_out ofq_tagged_out_chk #(.DEPTH(DEPTH)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_valid   (push_valid),
    .push_reject  (push_reject),
    .dma_en       (dma_en),
    .host_rd      (host_rd),
    .dma_ack      (dma_ack),
    .cmd_rd       (cmd_rd),
    .status_rd    (status_rd),
    .data_valid   (data_valid),
    .cmd_present  (cmd_present),
    .count        (count),
    .underrun     (underrun),
    .flush_active (flush_active),
    .svc_req      (svc_req),
    .drq_out      (drq_out),
    .intrq_out    (intrq_out)
);

// File: tb/test_ofq_tagged_out.sv
`timescale 1ns/1ps
module test_ofq_tagged_out;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 0, push_cmd = 0, thr_wr = 0, dma_en = 0;
    logic host_rd = 0, dma_ack = 0, cmd_rd = 0, status_rd = 0;
    logic [7:0] push_byte = '0;
    logic [CW-1:0] thr_val = '0;
    logic push_reject, data_valid, cmd_present, underrun, flush_active;
    logic svc_req, drq_out, intrq_out;
    logic [7:0] rd_byte, cmd_byte;
    logic [CW-1:0] count;

    always #2 clk = ~clk;

    ofq_tagged_out #(.DEPTH(DEPTH)) i_ofq_tagged_out (.*);

    int tests = 0, fails = 0;
    logic [8:0] mq[$];
    int m_thr = 0, m_pend = 0;
    bit m_ur = 0, m_rej = 0;

    task automatic check(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic bit exp_svc();
        int eff = (m_thr == 0) ? 1 : m_thr;
        return (mq.size() >= eff) || (m_pend > 0);
    endfunction

    task automatic compare_all();
        bit hd = mq.size() > 0 && !mq[0][8];
        bit hc = mq.size() > 0 && mq[0][8];
        check("R10 count (R7 ignored cmd read)", count, mq.size());
        check("R4 svc_req", svc_req, exp_svc());
        check("R5 flush_active", flush_active, m_pend > 0);
        check("R9 drq_out", drq_out, exp_svc() && dma_en);
        check("R9 intrq_out", intrq_out, exp_svc() && !dma_en);
        check("R8 underrun", underrun, m_ur);
        check("R3 push_reject", push_reject, m_rej);
        check("R2 data_valid", data_valid, hd);
        check("R6 cmd_present", cmd_present, hc);
        if (hd) check("R2 rd_byte order", rd_byte, mq[0][7:0]);
        if (hc) check("R6 cmd_byte order", cmd_byte, mq[0][7:0]);
    endtask

    task automatic step(input bit pv, input bit [7:0] pd, input bit pc,
                        input bit hr, input bit da, input bit cr, input bit sr,
                        input bit tw, input int tv, input bit de);
        bit full, empty, htag, drd, pok, dpop, cpop;
        push_valid = pv; push_byte = pd; push_cmd = pc;
        host_rd = hr; dma_ack = da; cmd_rd = cr; status_rd = sr;
        thr_wr = tw; thr_val = CW'(tv); dma_en = de;
        @(posedge clk);
        full  = mq.size() == DEPTH;
        empty = mq.size() == 0;
        htag  = !empty && mq[0][8];
        drd   = hr || da;
        pok   = pv && !full;
        dpop  = drd && !empty && !htag;
        cpop  = cr && !empty && htag;
        m_rej = pv && full;
        m_ur  = (drd && empty) || (m_ur && !sr);
        if (dpop || cpop) void'(mq.pop_front());
        if (cpop) m_pend--;
        if (pok) begin
            mq.push_back({pc, pd});
            if (pc) m_pend++;
        end
        if (tw) m_thr = tv;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input bit de);
        step(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, de);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 count", count, 0);
        check("R1 svc_req", svc_req, 0);
        check("R1 underrun", underrun, 0);
        check("R1 flush_active", flush_active, 0);
        check("R1 push_reject", push_reject, 0);
        check("R1 data_valid", data_valid, 0);
        check("R1 cmd_present", cmd_present, 0);

        // R4 threshold 4: three entries below, fourth reaches it
        step(0, 0, 0, 0, 0, 0, 0, 1, 4, 1);
        for (int i = 0; i < 4; i++) step(1, 8'(8'h10 + i), 0, 0, 0, 0, 0, 0, 0, 1);
        // R2 drain through both read kinds
        step(0, 0, 0, 1, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // R4 threshold zero acts as one
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        // R8 empty read, then set wins over clear, then clear
        step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        // R7 command read on empty
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        // R3 fill, then push into full
        step(0, 0, 0, 0, 0, 0, 0, 1, DEPTH, 1);
        for (int i = 0; i < DEPTH; i++) step(1, 8'(i * 3), 0, 0, 0, 0, 0, 0, 0, 1);
        step(1, 8'hEE, 1, 0, 0, 0, 0, 0, 0, 1);
        idle(1);
        for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0, 0, 0, 0, 0, 1);
        // R5 command ends a block below threshold; R6 data read blocked at command
        step(1, 8'hA1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 8'hC7, 1, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);   // R7 cmd_rd at data head
        step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);   // R6 blocked, no underrun
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        idle(0);

        // random mix
        void'($urandom(32'h5EED_0451));
        for (int n = 0; n < 4000; n++) begin
            bit pv = ($urandom % 3) != 0;
            bit pc = ($urandom % 8) == 0;
            bit hr = ($urandom % 4) == 0;
            bit da = ($urandom % 6) == 0;
            bit cr = ($urandom % 3) == 0;
            bit sr = ($urandom % 8) == 0;
            bit tw = ($urandom % 40) == 0;
            int tv = int'($urandom % (DEPTH + 2));
            bit de = ($urandom % 2) == 0;
            step(pv, 8'($urandom), pc, hr, da, cr, sr, tw, tv, de);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule